// File: doc/BRIEF.md
# Serial Frame Transmitter for a Multichannel DAC Loader

This block sits on the host side of a three-wire serial link to a multichannel digital-to-analog converter. A client presents a 5-bit channel number and a 14-bit output code on a valid/ready handshake. The block packs the pair into a 19-bit frame: channel first, then code, each most significant bit first. It places the frame at the top of a 24-bit word, with the five trailing bits driven as zero, and sends the word as three back-to-back 8-bit transfers inside one active-low frame strobe.

The serial clock is a divided copy of the system clock and rests low. Data changes on each rising edge so that the receiver can sample on the falling edge. After the strobe returns high, the block holds off the next frame for a parameterised number of cycles, which enforces the receiver's minimum spacing between writes. `HALF_DIV` sets the clock division and `GAP_CYC` sets the spacing. Elaboration checks compare both against the system clock period: each serial clock phase must last at least 16.667 ns, which also covers the 30 MHz ceiling and the 13 ns minimum phase width, and the hold-off must last at least 200 ns. A parameter selects between two internal byte engines. One shifts the most significant bit first. The other shifts the least significant bit first and is fed bit-reversed bytes, so that the order on the wire does not change.

Top module: `dac_frame_tx`

## Requirements
- R1: The first 19 bits sampled on the falling edges of `sclk_o` in a frame are `in_chan[4]` down to `in_chan[0]`, followed by `in_code[13]` down to `in_code[0]`, as captured at acceptance.
- R2: Every frame has exactly 24 falling edges of `sclk_o`, and the last 5 bits sent are 0.
- R3: `sync_n_o` stays low without a break from acceptance until `HALF_DIV` cycles after the 24th falling edge, so a frame lasts 49*`HALF_DIV` cycles. `sclk_o` is never high while `sync_n_o` is high.
- R4: `sclk_o` rises `HALF_DIV` cycles after `sync_n_o` falls. Every high and low phase of `sclk_o` inside a frame lasts exactly `HALF_DIV` cycles. `sdo_o` changes only in the cycle in which `sclk_o` rises.
- R5: After `sync_n_o` rises, `in_ready` stays low for exactly `GAP_CYC` cycles, so `sync_n_o` stays high for at least `GAP_CYC`+1 cycles between frames.
- R6: A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from that edge until the gap has elapsed. `done_o` is a single-cycle pulse in the cycle in which `sync_n_o` returns high.
- R7: With `LSB_FIRST_ENGINE`=1, the wire sequence and timing are identical to those of the default engine for the same input.
- R8: During and right after reset, `sync_n_o`=1, `sclk_o`=0, `sdo_o`=0, `done_o`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Client offers a channel/code pair |
| in_ready | output | 1 | Block can accept a pair this cycle |
| in_chan | input | ADDR_W | Channel number |
| in_code | input | CODE_W | Output code |
| sclk_o | output | 1 | Serial clock, idles low |
| sync_n_o | output | 1 | Active-low frame strobe |
| sdo_o | output | 1 | Serial data, changes on the rising edge of sclk_o |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bench sends all 32 channels twice. The first pass uses a code derived arithmetically from the channel number. The second pass uses the complement of that code and varies the idle time before each offer, which separates channel bits from code bits and catches any misplaced byte boundary. A walking single one through the 14 code bits, together with all-zero, all-one and alternating codes, exposes bit-order and reversal faults. The fixed 24-bit length and the zero tail show up as well. Two instances, one per byte engine, decode the same stimulus, and their wire words are compared with each other and with the expected word. Frames are offered back to back and after idle pauses, which checks both the exact hold-off length and the strobe spacing.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_HIGH,
      ST_LOW,
      ST_GAP
   } tx_state_e;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dac_frame_pack.sv
module dac_frame_pack #(
   parameter int ADDR_W = 5,
   parameter int CODE_W = 14,
   parameter int BYTE_W = 8,
   parameter int NBYTES = 3,
   parameter bit REV    = 1'b0
) (
   input  logic [ADDR_W-1:0]        chan,
   input  logic [CODE_W-1:0]        code,
   output logic [NBYTES*BYTE_W-1:0] word
);
   localparam int WORD_W = NBYTES * BYTE_W;
   localparam int PAD    = WORD_W - ADDR_W - CODE_W;

   logic [WORD_W-1:0] raw;

   // left-justified: frame occupies the top bits, tail padded with zeros
   assign raw = WORD_W'({chan, code}) << PAD;

   generate
      if (REV) begin : g_rev
         for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
               assign word[b*BYTE_W + k] = raw[b*BYTE_W + BYTE_W - 1 - k];
            end
         end
      end else begin : g_fwd
         assign word = raw;
      end
   endgenerate

endmodule

// File: rtl/dac_byte_engine.sv
module dac_byte_engine #(
   parameter int BYTE_W    = 8,
   parameter bit LSB_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_byte,
   input  logic              shift,
   output logic              bit_o
);
   logic [BYTE_W-1:0] sr;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sr <= '0;
            else if (load)   sr <= load_byte;
            else if (shift)  sr <= {1'b0, sr[BYTE_W-1:1]};
         end
         assign bit_o = sr[0];
      end else begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sr <= '0;
            else if (load)   sr <= load_byte;
            else if (shift)  sr <= {sr[BYTE_W-2:0], 1'b0};
         end
         assign bit_o = sr[BYTE_W-1];
      end
   endgenerate

   // R7: a byte is never reloaded in the same cycle it is shifted
   a_r7_load_shift_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift));

endmodule

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (restart)        cnt <= '0;
      else if (cnt != limit)   cnt <= cnt + 1'b1;
   end

   assign expire = (cnt == limit);

endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
   import dac_frame_pkg::*;
#(
   parameter int ADDR_W           = 5,
   parameter int CODE_W           = 14,
   parameter int BYTE_W           = 8,
   parameter int HALF_DIV         = 2,
   parameter int GAP_CYC          = 20,
   parameter int CLK_PERIOD_PS    = 10000,
   parameter bit LSB_FIRST_ENGINE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_chan,
   input  logic [CODE_W-1:0] in_code,
   output logic              sclk_o,
   output logic              sync_n_o,
   output logic              sdo_o,
   output logic              done_o
);
   localparam int NBYTES = int'(ceil_div(ADDR_W + CODE_W, BYTE_W));
   localparam int WORD_W = NBYTES * BYTE_W;
   localparam int CNT_W  = $clog2(int'(max_u(HALF_DIV, GAP_CYC)) + 1);
   localparam int IDX_W  = $clog2(NBYTES + 1);
   localparam int BIT_W  = $clog2(BYTE_W);

   initial begin
      assert (HALF_DIV >= 1 && GAP_CYC >= 2)
         else $error("divider or gap too small");
      assert (HALF_DIV * CLK_PERIOD_PS >= 16667)
         else $error("serial clock phase shorter than limit");
      assert (GAP_CYC * CLK_PERIOD_PS >= 200000)
         else $error("inter-frame gap shorter than 200 ns");
      assert (BYTE_W >= 2 && WORD_W >= ADDR_W + CODE_W)
         else $error("bad byte geometry");
   end

   tx_state_e           state;
   logic [WORD_W-1:0]   packed_w;
   logic [WORD_W-1:0]   word_q;
   logic [BYTE_W-1:0]   byte_q [NBYTES];
   logic [IDX_W-1:0]    byte_idx;
   logic [IDX_W-1:0]    nxt_idx;
   logic [IDX_W-1:0]    nxt_sel;
   logic [BIT_W-1:0]    bit_cnt;
   logic [CNT_W-1:0]    limit;
   logic                expire;
   logic                restart;
   logic                accept;
   logic                last_bit;
   logic                eng_load;
   logic                eng_shift;
   logic                eng_bit;
   logic [BYTE_W-1:0]   eng_byte;

   assign in_ready = (state == ST_IDLE);
   assign accept   = in_valid && in_ready;

   dac_frame_pack #(
      .ADDR_W (ADDR_W),
      .CODE_W (CODE_W),
      .BYTE_W (BYTE_W),
      .NBYTES (NBYTES),
      .REV    (LSB_FIRST_ENGINE)
   ) u_pack (
      .chan (in_chan),
      .code (in_code),
      .word (packed_w)
   );

   generate
      for (genvar i = 0; i < NBYTES; i++) begin : g_slice
         assign byte_q[i] = word_q[WORD_W-1-i*BYTE_W -: BYTE_W];
      end
   endgenerate

   assign nxt_idx  = byte_idx + 1'b1;
   assign nxt_sel  = (nxt_idx < IDX_W'(NBYTES)) ? nxt_idx : '0;
   assign last_bit = (bit_cnt == BIT_W'(BYTE_W - 1));
   assign eng_byte = (state == ST_IDLE) ? packed_w[WORD_W-1 -: BYTE_W] : byte_q[nxt_sel];
   assign eng_load = accept ||
                     ((state == ST_HIGH) && expire && last_bit && (nxt_idx < IDX_W'(NBYTES)));
   assign eng_shift = expire && ((state == ST_LEAD) ||
                     ((state == ST_LOW) && (byte_idx != IDX_W'(NBYTES))));

   dac_byte_engine #(
      .BYTE_W    (BYTE_W),
      .LSB_FIRST (LSB_FIRST_ENGINE)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (eng_load),
      .load_byte (eng_byte),
      .shift     (eng_shift),
      .bit_o     (eng_bit)
   );

   always_comb begin
      case (state)
         ST_IDLE: limit = '0;
         ST_GAP:  limit = CNT_W'(GAP_CYC - 1);
         default: limit = CNT_W'(HALF_DIV - 1);
      endcase
   end

   assign restart = accept || ((state != ST_IDLE) && expire);

   dac_phase_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .limit   (limit),
      .expire  (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         word_q   <= '0;
         byte_idx <= '0;
         bit_cnt  <= '0;
         sclk_o   <= 1'b0;
         sync_n_o <= 1'b1;
         sdo_o    <= 1'b0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  state    <= ST_LEAD;
                  word_q   <= packed_w;
                  byte_idx <= '0;
                  bit_cnt  <= '0;
                  sync_n_o <= 1'b0;
               end
            end
            ST_LEAD: begin
               if (expire) begin
                  state  <= ST_HIGH;
                  sclk_o <= 1'b1;
                  sdo_o  <= eng_bit;
               end
            end
            ST_HIGH: begin
               if (expire) begin
                  state  <= ST_LOW;
                  sclk_o <= 1'b0;
                  if (last_bit) begin
                     bit_cnt  <= '0;
                     byte_idx <= nxt_idx;
                  end else begin
                     bit_cnt  <= bit_cnt + 1'b1;
                  end
               end
            end
            ST_LOW: begin
               if (expire) begin
                  if (byte_idx == IDX_W'(NBYTES)) begin
                     state    <= ST_GAP;
                     sync_n_o <= 1'b1;
                     done_o   <= 1'b1;
                  end else begin
                     state  <= ST_HIGH;
                     sclk_o <= 1'b1;
                     sdo_o  <= eng_bit;
                  end
               end
            end
            ST_GAP: begin
               if (expire) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R3: serial clock only pulses while the strobe is low
   a_r3_clock_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_o |-> !sync_n_o);

   // R4: data moves only together with a rising serial clock
   a_r4_data_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(sclk_o) |-> $stable(sdo_o));

   // R6: a frame opens only on a handshake
   a_r6_open_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_n_o) |-> $past(in_valid && in_ready));

   // R6: end pulse lasts one cycle
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6: end pulse coincides with the strobe release
   a_r6_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $rose(sync_n_o));

   // R5: no new request is taken as the strobe rises
   a_r5_busy_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_n_o) |-> !in_ready);

endmodule

// File: tb/dac_wire_mon.sv
module dac_wire_mon #(
   parameter int HALF_DIV = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sclk,
   input  logic        sync_n,
   input  logic        sdo,
   output logic [31:0] cap_word,
   output int          cap_bits,
   output int          frame_len,
   output int          gap_last,
   output int          lead,
   output int          width_err,
   output int          stray
);
   logic prev_sclk, prev_sync, prev_sdo, in_lead;
   int   run, frame_cnt, gap_cnt;

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_sclk = 1'b0; prev_sync = 1'b1; prev_sdo = 1'b0; in_lead = 1'b0;
         run = 0; frame_cnt = 0; gap_cnt = 0;
         cap_word = '0; cap_bits = 0; frame_len = 0; gap_last = 0; lead = 0;
         width_err = 0; stray = 0;
      end else begin
         if (sclk && sync_n) stray++;
         if ((sdo !== prev_sdo) && !(sclk && !prev_sclk)) stray++;
         if (prev_sync && !sync_n) begin
            gap_last = gap_cnt; cap_word = '0; cap_bits = 0;
            frame_cnt = 1; run = 1; lead = 1; in_lead = 1'b1;
         end else if (!sync_n) begin
            frame_cnt++;
            if (sclk != prev_sclk) begin
               if (run != HALF_DIV) width_err++;
               run = 1; in_lead = 1'b0;
               if (!sclk) begin
                  cap_word = {cap_word[30:0], sdo};
                  cap_bits++;
               end
            end else begin
               run++;
               if (in_lead) lead++;
            end
         end else if (!prev_sync && sync_n) begin
            frame_len = frame_cnt;
            if (run != HALF_DIV) width_err++;
            gap_cnt = 1;
         end else begin
            gap_cnt++;
         end
         prev_sclk = sclk; prev_sync = sync_n; prev_sdo = sdo;
      end
   end
endmodule

// File: tb/test_dac_frame_tx.sv
module test_dac_frame_tx;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_DIV   = 2;
   localparam int GAP_CYC    = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  in_chan = '0;
   logic [13:0] in_code = '0;
   logic        rdy_a, sclk_a, sync_a, sdo_a, done_a;
   logic        rdy_b, sclk_b, sync_b, sdo_b, done_b;
   logic [31:0] word_a, word_b;
   int bits_a, len_a, gap_a, lead_a, werr_a, stray_a;
   int bits_b, len_b, gap_b, lead_b, werr_b, stray_b;
   int checks = 0;
   int errors = 0;
   int frames = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dac_frame_tx #(.HALF_DIV(HALF_DIV), .GAP_CYC(GAP_CYC), .CLK_PERIOD_PS(CLK_PERIOD*1000),
                  .LSB_FIRST_ENGINE(1'b0)) i_dac_frame_tx (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a),
      .in_chan(in_chan), .in_code(in_code), .sclk_o(sclk_a), .sync_n_o(sync_a),
      .sdo_o(sdo_a), .done_o(done_a));

   dac_frame_tx #(.HALF_DIV(HALF_DIV), .GAP_CYC(GAP_CYC), .CLK_PERIOD_PS(CLK_PERIOD*1000),
                  .LSB_FIRST_ENGINE(1'b1)) i_dac_frame_tx_lsb (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b),
      .in_chan(in_chan), .in_code(in_code), .sclk_o(sclk_b), .sync_n_o(sync_b),
      .sdo_o(sdo_b), .done_o(done_b));

   dac_wire_mon #(.HALF_DIV(HALF_DIV)) u_mon_a (
      .clk(clk), .rst_n(rst_n), .sclk(sclk_a), .sync_n(sync_a), .sdo(sdo_a),
      .cap_word(word_a), .cap_bits(bits_a), .frame_len(len_a), .gap_last(gap_a),
      .lead(lead_a), .width_err(werr_a), .stray(stray_a));

   dac_wire_mon #(.HALF_DIV(HALF_DIV)) u_mon_b (
      .clk(clk), .rst_n(rst_n), .sclk(sclk_b), .sync_n(sync_b), .sdo(sdo_b),
      .cap_word(word_b), .cap_bits(bits_b), .frame_len(len_b), .gap_last(gap_b),
      .lead(lead_b), .width_err(werr_b), .stray(stray_b));

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [4:0] ch, input logic [13:0] cd, input int pause);
      logic [31:0] exp_word;
      int n;
      repeat (pause) tick();
      in_valid = 1'b1;
      in_chan  = ch;
      in_code  = cd;
      while (!rdy_a) tick();
      tick();
      in_valid = 1'b0;
      chk(!rdy_a && !sync_a, "R6 ready low and strobe low after accept", {rdy_a, sync_a}, 0);
      while (!done_a) tick();
      exp_word = {8'h00, ch, cd, 5'b00000};
      chk(word_a == exp_word, "R1 frame content", word_a, exp_word);
      chk(word_b == word_a && done_b && rdy_b == rdy_a, "R7 lsb-first engine matches", word_b, word_a);
      chk(bits_a == 24 && word_a[4:0] == 5'd0, "R2 24 clocks, zero tail", bits_a, 24);
      chk(len_a == 49*HALF_DIV && len_b == len_a, "R3 strobe low length", len_a, 49*HALF_DIV);
      chk(stray_a == 0 && stray_b == 0, "R3 R4 no clock or data motion outside", stray_a + stray_b, 0);
      chk(lead_a == HALF_DIV && werr_a == 0 && werr_b == 0, "R4 lead and phase widths",
          lead_a + werr_a + werr_b, HALF_DIV);
      if (frames > 0)
         chk(gap_a >= GAP_CYC + 1, "R5 strobe high between frames", gap_a, GAP_CYC + 1);
      tick();
      chk(!done_a && sync_a, "R6 done single cycle", done_a, 0);
      n = 1;
      while (!rdy_a) begin
         tick();
         n++;
      end
      chk(n == GAP_CYC, "R5 ready hold-off", n, GAP_CYC);
      frames++;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", frames, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) tick();
      // R8: reset state while held
      chk(sync_a && !sclk_a && !sdo_a && !done_a && rdy_a, "R8 reset outputs",
          {sync_a, sclk_a, sdo_a, done_a, rdy_a}, 5'b10001);
      rst_n = 1'b1;
      tick();
      chk(sync_b && !sclk_b && !sdo_b && !done_b && rdy_b, "R8 outputs after release",
          {sync_b, sclk_b, sdo_b, done_b, rdy_b}, 5'b10001);
      for (int ch = 0; ch < 32; ch++)
         send(5'(ch), 14'((ch * 1031 + 77) & 16'h3FFF), 0);
      for (int ch = 0; ch < 32; ch++)
         send(5'(ch), ~14'((ch * 1031 + 77) & 16'h3FFF), ch % 3);
      for (int b = 0; b < 14; b++)
         send(5'(31 - b), 14'(1) << b, 0);
      send(5'd31, 14'h3FFF, 0);
      send(5'd0,  14'h0000, 5);
      send(5'd21, 14'h2AAA, 0);
      send(5'd10, 14'h1555, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule